// File: doc/BRIEF.md
# Endian-Selectable Fetch and Data Memory Adapter

This block sits between a small byte-addressed memory and a DSP core. The core sees two ports. One is a 128-bit instruction fetch port that returns an aligned group of sixteen bytes. The other is a 64-bit data port that reads and writes a byte, a 16-bit word, a 32-bit long or four words at a time. A static mode input selects little or big endian interpretation of the bytes in memory.

Memory itself is neutral: it holds bytes. The mode only decides how bytes combine into 16-bit values. With `bigEndian` = 0, the halfword at even address A is H(A) = {mem[A+1], mem[A]}. With `bigEndian` = 1, it is H(A) = {mem[A], mem[A+1]}. The fetch port always packs eight instructions with the lowest address in the lowest lane, whatever the mode. The data port steers bytes according to the access size and the mode. Writes use the same right-justified lane rules as reads, so a value written in one size and read back in the same size and mode returns unchanged.

Both ports can be served in the same cycle. Each returns a registered response one cycle after its request.

Top module: `endian_bus_adapter`

## Requirements
- R1: One cycle after `fetchValid`, `fetchData` holds H(B), H(B+2) … H(B+14) in lanes [15:0] up to [127:112], in ascending order. B is `fetchAddr` with its low four bits cleared, so those four bits have no effect.
- R2: The fetch lane order is the same in both modes. Only the byte pairing inside each halfword H follows the mode.
- R3: A four-word read (`dataSize` 2'b11, address a multiple of 8) returns {H(A+6),H(A+4),H(A+2),H(A)} in little endian mode and {H(A),H(A+2),H(A+4),H(A+6)} in big endian mode.
- R4: A long read (`dataSize` 2'b10, address a multiple of 4) returns {32'0,H(A+2),H(A)} in little endian mode and {32'0,H(A),H(A+2)} in big endian mode.
- R5: A word read (`dataSize` 2'b01, even address) returns {48'0,H(A)}.
- R6: A byte read (`dataSize` 2'b00) returns {56'0,mem[A]} in both modes. At an even address this is the high half of H(A) in big endian mode and the low half in little endian mode.
- R7: An aligned write with `dataWrite` = 1 stores right-justified `dataWdata` so that a read of the same size, address and mode returns it. Only the addressed bytes of memory change.
- R8: A request whose address is not a multiple of its size in bytes sets `dataErr` with its response, leaves memory unchanged and leaves `dataRdata` unchanged. `dataRdata` changes only on aligned reads.
- R9: Every request gets a one-cycle `fetchRvalid` or `dataRvalid` pulse in the cycle after it. No pulse appears without a request. `dataErr` is never set without `dataRvalid`.
- R10: The mode is captured from `bigEndian` only in cycles with no request on either port, and it resets to little endian. A change of `bigEndian` during back-to-back requests has no effect until an idle cycle.
- R11: A fetch and a data write issued in the same cycle to the same fetch group are both served. The fetch returns the memory contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bigEndian | input | 1 | Mode request: 1 big endian, 0 little endian |
| fetchValid | input | 1 | Fetch request |
| fetchAddr | input | ADDR_W | Fetch byte address; low four bits ignored |
| fetchData | output | 128 | Eight packed 16-bit instructions |
| fetchRvalid | output | 1 | Fetch response strobe |
| dataValid | input | 1 | Data request |
| dataWrite | input | 1 | 1 write, 0 read |
| dataSize | input | 2 | 00 byte, 01 word, 10 long, 11 four-word |
| dataAddr | input | ADDR_W | Data byte address |
| dataWdata | input | 64 | Right-justified write data |
| dataRdata | output | 64 | Right-justified read data |
| dataRvalid | output | 1 | Data response strobe |
| dataErr | output | 1 | Misaligned request flag, with dataRvalid |

## Verification
Two overlaps are provoked on purpose. In the first, a fetch and a four-word data write hit the same sixteen-byte group in one cycle. The fetch response is compared with the model's contents from before the write, and a later fetch must show the new contents. In the second, the mode input flips while data reads arrive back to back. The read issued in the same cycle as the flip must still use the old mode, and the first read after an idle cycle must use the new one.

// File: rtl/eba_pkg.sv
package eba_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } accSize_e;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic       fetchGo;   // fetch request accepted this cycle
    logic       readGo;    // aligned data read
    logic       writeGo;   // aligned data write
    logic       reject;    // misaligned data request
    logic       dataAck;   // any data request
    logic       bigMode;   // captured endian mode
    logic [3:0] nBytes;    // bytes touched by the data access
  } strobes_t;

  function automatic logic [3:0] sizeBytes(input accSize_e sz);
    return 4'd1 << sz;
  endfunction

endpackage

// File: rtl/eba_ctrl.sv
module eba_ctrl
  import eba_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bigEndian,
  input  logic       fetchValid,
  input  logic       dataValid,
  input  logic       dataWrite,
  input  logic [1:0] dataSize,
  input  logic [2:0] addrLow,
  output strobes_t   stb
);

  logic       modeBig;
  logic [3:0] nBytes;
  logic [2:0] alignMask;
  logic       misaligned;

  // Mode is taken only when neither port presents a request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBig <= 1'b0;
    end else if (!fetchValid && !dataValid) begin
      modeBig <= bigEndian;
    end
  end

  always_comb begin
    nBytes     = sizeBytes(accSize_e'(dataSize));
    alignMask  = 3'(nBytes - 4'd1);
    misaligned = |(addrLow & alignMask);
  end

  always_comb begin
    stb.fetchGo = fetchValid;
    stb.readGo  = dataValid && !dataWrite && !misaligned;
    stb.writeGo = dataValid &&  dataWrite && !misaligned;
    stb.reject  = dataValid && misaligned;
    stb.dataAck = dataValid;
    stb.bigMode = modeBig;
    stb.nBytes  = nBytes;
  end

endmodule

// File: rtl/eba_datapath.sv
module eba_datapath
  import eba_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FETCH_BYTES = 16,
  parameter int DATA_BYTES  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 stb,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic [ADDR_W-1:0]        dataAddr,
  input  logic [DATA_BYTES*8-1:0]  dataWdata,
  output logic [FETCH_BYTES*8-1:0] fetchData,
  output logic                     fetchRvalid,
  output logic [DATA_BYTES*8-1:0]  dataRdata,
  output logic                     dataRvalid,
  output logic                     dataErr
);

  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int FETCH_W   = FETCH_BYTES * 8;
  localparam int DATA_W    = DATA_BYTES * 8;

  logic [7:0]        mem [MEM_BYTES];
  logic [ADDR_W-1:0] fetchBase;
  logic [FETCH_W-1:0] fetchNext;
  logic [DATA_W-1:0]  dataNext;
  logic [3:0]         laneOff [DATA_BYTES];
  logic [7:0]         wrByte  [DATA_BYTES];
  logic               laneUsed[DATA_BYTES];

  assign fetchBase = fetchAddr & ~ADDR_W'(FETCH_BYTES - 1);

  // Fetch path: halfword order fixed, bytes paired per mode
  for (genvar j = 0; j < FETCH_BYTES; j++) begin : g_fetchLane
    localparam int PAIRED = j ^ 1;
    always_comb begin
      if (stb.bigMode) fetchNext[j*8 +: 8] = mem[fetchBase + ADDR_W'(PAIRED)];
      else             fetchNext[j*8 +: 8] = mem[fetchBase + ADDR_W'(j)];
    end
  end

  // Data path: byte order reversed across the access in big endian.
  // The permutation is its own inverse, so reads and writes share it.
  for (genvar j = 0; j < DATA_BYTES; j++) begin : g_dataLane
    always_comb begin
      laneUsed[j] = 4'(j) < stb.nBytes;
      laneOff[j]  = stb.bigMode ? (stb.nBytes - 4'(j) - 4'd1) : 4'(j);
      wrByte[j]   = dataWdata[laneOff[j]*8 +: 8];
      dataNext[j*8 +: 8] = laneUsed[j] ? mem[dataAddr + ADDR_W'(laneOff[j])] : 8'h00;
    end
  end

  // Storage: only the addressed bytes are written
  always_ff @(posedge clk) begin
    if (stb.writeGo) begin
      for (int k = 0; k < DATA_BYTES; k++) begin
        if (laneUsed[k]) mem[dataAddr + ADDR_W'(k)] <= wrByte[k];
      end
    end
  end

  // Registered responses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchRvalid <= 1'b0;
      fetchData   <= '0;
      dataRvalid  <= 1'b0;
      dataErr     <= 1'b0;
      dataRdata   <= '0;
    end else begin
      fetchRvalid <= stb.fetchGo;
      dataRvalid  <= stb.dataAck;
      dataErr     <= stb.reject;
      if (stb.fetchGo) fetchData <= fetchNext;
      if (stb.readGo)  dataRdata <= dataNext;
    end
  end

endmodule

// File: rtl/endian_bus_adapter.sv
module endian_bus_adapter
  import eba_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FETCH_BYTES = 16,
  parameter int DATA_BYTES  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     bigEndian,
  input  logic                     fetchValid,
  input  logic [ADDR_W-1:0]        fetchAddr,
  output logic [FETCH_BYTES*8-1:0] fetchData,
  output logic                     fetchRvalid,
  input  logic                     dataValid,
  input  logic                     dataWrite,
  input  logic [1:0]               dataSize,
  input  logic [ADDR_W-1:0]        dataAddr,
  input  logic [DATA_BYTES*8-1:0]  dataWdata,
  output logic [DATA_BYTES*8-1:0]  dataRdata,
  output logic                     dataRvalid,
  output logic                     dataErr
);

  strobes_t ctrlStb;

  eba_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bigEndian  (bigEndian),
    .fetchValid (fetchValid),
    .dataValid  (dataValid),
    .dataWrite  (dataWrite),
    .dataSize   (dataSize),
    .addrLow    (dataAddr[2:0]),
    .stb        (ctrlStb)
  );

  eba_datapath #(
    .ADDR_W      (ADDR_W),
    .FETCH_BYTES (FETCH_BYTES),
    .DATA_BYTES  (DATA_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (ctrlStb),
    .fetchAddr   (fetchAddr),
    .dataAddr    (dataAddr),
    .dataWdata   (dataWdata),
    .fetchData   (fetchData),
    .fetchRvalid (fetchRvalid),
    .dataRdata   (dataRdata),
    .dataRvalid  (dataRvalid),
    .dataErr     (dataErr)
  );

endmodule

// File: rtl/eba_checker.sv
module eba_checker (
  input logic       clk,
  input logic       rstN,
  input logic       fetchValid,
  input logic       fetchRvalid,
  input logic       dataValid,
  input logic [1:0] dataSize,
  input logic [2:0] addrLow,
  input logic       dataRvalid,
  input logic       dataErr,
  input logic       modeBig
);

  logic [2:0] sizeMask;
  assign sizeMask = 3'((4'd1 << dataSize) - 4'd1);

  // R9
  fetch_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> fetchRvalid);

  // R9
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !fetchRvalid);

  // R9
  data_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> dataRvalid);

  // R9
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> !dataRvalid);

  // R8
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && ((addrLow & sizeMask) != 3'b000)) |=> dataErr);

  // R8
  aligned_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && ((addrLow & sizeMask) == 3'b000)) |=> !dataErr);

  // R9
  err_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataErr |-> dataRvalid);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid || dataValid) |=> $stable(modeBig));

endmodule

bind endian_bus_adapter eba_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .fetchValid  (fetchValid),
  .fetchRvalid (fetchRvalid),
  .dataValid   (dataValid),
  .dataSize    (dataSize),
  .addrLow     (dataAddr[2:0]),
  .dataRvalid  (dataRvalid),
  .dataErr     (dataErr),
  .modeBig     (ctrlStb.bigMode)
);

// File: tb/endian_bus_adapter_bench.sv
module endian_bus_adapter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bigEndian = 1'b0;
  logic         fetchValid = 1'b0;
  logic [7:0]   fetchAddr = '0;
  logic [127:0] fetchData;
  logic         fetchRvalid;
  logic         dataValid = 1'b0;
  logic         dataWrite = 1'b0;
  logic [1:0]   dataSize = '0;
  logic [7:0]   dataAddr = '0;
  logic [63:0]  dataWdata = '0;
  logic [63:0]  dataRdata;
  logic         dataRvalid;
  logic         dataErr;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  finished = 0;
  logic [7:0] model [256];

  // {big, write, size, addr, wdata}
  localparam logic [75:0] VECS [NV] = '{
    {1'b0, 1'b1, 2'd3, 8'h40, 64'h1122334455667788},
    {1'b0, 1'b0, 2'd3, 8'h40, 64'h0},
    {1'b1, 1'b0, 2'd3, 8'h40, 64'h0},
    {1'b1, 1'b0, 2'd2, 8'h44, 64'h0},
    {1'b0, 1'b0, 2'd2, 8'h44, 64'h0},
    {1'b1, 1'b1, 2'd1, 8'h42, 64'h000000000000A1B2},
    {1'b0, 1'b0, 2'd1, 8'h42, 64'h0},
    {1'b1, 1'b0, 2'd0, 8'h42, 64'h0},
    {1'b0, 1'b0, 2'd0, 8'h43, 64'h0},
    {1'b1, 1'b1, 2'd2, 8'h48, 64'h00000000DEADBEEF},
    {1'b0, 1'b0, 2'd3, 8'h48, 64'h0},
    {1'b1, 1'b1, 2'd0, 8'h4F, 64'h000000000000005A},
    {1'b1, 1'b0, 2'd3, 8'h48, 64'h0},
    {1'b0, 1'b0, 2'd2, 8'h10, 64'h0}
  };

  endian_bus_adapter u_endian_bus_adapter (
    .clk, .rstN, .bigEndian, .fetchValid, .fetchAddr, .fetchData, .fetchRvalid,
    .dataValid, .dataWrite, .dataSize, .dataAddr, .dataWdata, .dataRdata,
    .dataRvalid, .dataErr
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] hw(input logic [7:0] a, input logic big);
    return big ? {model[a], model[8'(a + 1)]} : {model[8'(a + 1)], model[a]};
  endfunction

  function automatic logic [63:0] expRead(input logic [1:0] sz, input logic [7:0] a, input logic big);
    case (sz)
      2'd0: return {56'h0, model[a]};
      2'd1: return {48'h0, hw(a, big)};
      2'd2: return big ? {32'h0, hw(a, big), hw(8'(a+2), big)}
                       : {32'h0, hw(8'(a+2), big), hw(a, big)};
      default: return big ? {hw(a, big), hw(8'(a+2), big), hw(8'(a+4), big), hw(8'(a+6), big)}
                          : {hw(8'(a+6), big), hw(8'(a+4), big), hw(8'(a+2), big), hw(a, big)};
    endcase
  endfunction

  function automatic logic [127:0] expFetch(input logic [7:0] a, input logic big);
    logic [127:0] r;
    logic [7:0] b;
    b = a & 8'hF0;
    for (int i = 0; i < 8; i++) r[i*16 +: 16] = hw(8'(b + 8'(2*i)), big);
    return r;
  endfunction

  task automatic setHw(input logic [7:0] a, input logic big, input logic [15:0] v);
    if (big) begin model[a] = v[15:8]; model[8'(a+1)] = v[7:0]; end
    else     begin model[a] = v[7:0];  model[8'(a+1)] = v[15:8]; end
  endtask

  task automatic modelWrite(input logic [1:0] sz, input logic [7:0] a, input logic big, input logic [63:0] wd);
    case (sz)
      2'd0: model[a] = wd[7:0];
      2'd1: setHw(a, big, wd[15:0]);
      2'd2: begin
        setHw(a, big, big ? wd[31:16] : wd[15:0]);
        setHw(8'(a+2), big, big ? wd[15:0] : wd[31:16]);
      end
      default:
        for (int i = 0; i < 4; i++) setHw(8'(a + 8'(2*i)), big, big ? wd[(3-i)*16 +: 16] : wd[i*16 +: 16]);
    endcase
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string sizeTag(input logic [1:0] sz);
    case (sz)
      2'd0: return "R6";
      2'd1: return "R5";
      2'd2: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic dataOp(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                        input logic [63:0] wd, input logic big);
    logic mis;
    logic [63:0] exp;
    logic [2:0] msk;
    msk = 3'((4'd1 << sz) - 4'd1);
    mis = |(a[2:0] & msk);
    exp = (wr || mis) ? dataRdata : expRead(sz, a, big);
    @(negedge clk);
    dataValid = 1'b1; dataWrite = wr; dataSize = sz; dataAddr = a; dataWdata = wd;
    @(negedge clk);
    dataValid = 1'b0; dataWrite = 1'b0;
    check(dataRvalid === 1'b1, "R9 data response", 128'(dataRvalid), 128'(1));
    check(dataErr === mis, "R8 error flag", 128'(dataErr), 128'(mis));
    check(dataRdata === exp, (wr || mis) ? "R8 rdata hold" : sizeTag(sz), 128'(dataRdata), 128'(exp));
    if (wr && !mis) modelWrite(sz, a, big, wd);
  endtask

  task automatic fetchOp(input logic [7:0] a, input logic big, input string tag);
    logic [127:0] exp;
    exp = expFetch(a, big);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a;
    @(negedge clk);
    fetchValid = 1'b0;
    check(fetchRvalid === 1'b1, "R9 fetch response", 128'(fetchRvalid), 128'(1));
    check(fetchData === exp, tag, fetchData, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    logic [127:0] oldF;
    logic [7:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    check(fetchRvalid === 1'b0 && dataRvalid === 1'b0 && dataErr === 1'b0,
          "R9 reset outputs", 128'({fetchRvalid, dataRvalid, dataErr}), 128'(0));

    // Preload memory with four-word little endian writes (R7)
    bigEndian = 1'b0;
    for (int g = 0; g < 32; g++) begin
      logic [63:0] wd;
      for (int k = 0; k < 8; k++) wd[k*8 +: 8] = 8'((g*8 + k) * 37 + 11);
      dataOp(1'b1, 2'd3, 8'(g*8), wd, 1'b0);
    end

    // Vector table (R3 R4 R5 R6 R7)
    for (int v = 0; v < NV; v++) begin
      bigEndian = VECS[v][75];
      dataOp(VECS[v][74], VECS[v][73:72], VECS[v][71:64], VECS[v][63:0], VECS[v][75]);
    end

    // R1 R2: fetch in both modes, low address bits ignored
    bigEndian = 1'b0;
    fetchOp(8'h40, 1'b0, "R1 fetch LE");
    fetchOp(8'h4B, 1'b0, "R1 fetch low bits");
    bigEndian = 1'b1;
    fetchOp(8'h40, 1'b1, "R2 fetch BE");
    fetchOp(8'hF7, 1'b1, "R2 fetch BE top");

    // R8: misaligned requests
    bigEndian = 1'b0;
    dataOp(1'b0, 2'd1, 8'h20, 64'h0, 1'b0);
    dataOp(1'b0, 2'd1, 8'h21, 64'h0, 1'b0);
    dataOp(1'b1, 2'd2, 8'h22, 64'hFFFFFFFF, 1'b0);
    dataOp(1'b1, 2'd3, 8'h24, 64'hFFFFFFFFFFFFFFFF, 1'b0);
    dataOp(1'b0, 2'd3, 8'h20, 64'h0, 1'b0);
    dataOp(1'b0, 2'd3, 8'h28, 64'h0, 1'b0);

    // R7: byte write touches only its byte
    snap = model[8'h31];
    dataOp(1'b1, 2'd0, 8'h30, 64'h00000000000000C3, 1'b0);
    dataOp(1'b0, 2'd0, 8'h31, 64'h0, 1'b0);
    check(dataRdata[7:0] === snap, "R7 neighbour byte", 128'(dataRdata[7:0]), 128'(snap));

    // R10: mode change during back-to-back reads is deferred
    bigEndian = 1'b0;
    @(negedge clk);
    dataValid = 1'b1; dataWrite = 1'b0; dataSize = 2'd1; dataAddr = 8'h42;
    @(negedge clk);
    check(dataRdata === expRead(2'd1, 8'h42, 1'b0), "R10 first read",
          128'(dataRdata), 128'(expRead(2'd1, 8'h42, 1'b0)));
    bigEndian = 1'b1; dataAddr = 8'h44;
    @(negedge clk);
    dataValid = 1'b0;
    check(dataRdata === expRead(2'd1, 8'h44, 1'b0), "R10 mode held",
          128'(dataRdata), 128'(expRead(2'd1, 8'h44, 1'b0)));
    dataOp(1'b0, 2'd1, 8'h44, 64'h0, 1'b1);

    // R11: fetch and write to the same group in one cycle
    oldF = expFetch(8'h40, 1'b1);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 8'h40;
    dataValid = 1'b1; dataWrite = 1'b1; dataSize = 2'd3; dataAddr = 8'h40;
    dataWdata = 64'hCAFE0123BEEF4567;
    @(negedge clk);
    fetchValid = 1'b0; dataValid = 1'b0; dataWrite = 1'b0;
    check(fetchData === oldF, "R11 fetch sees old", fetchData, oldF);
    check(dataRvalid === 1'b1 && dataErr === 1'b0, "R11 write served",
          128'({dataRvalid, dataErr}), 128'(2));
    modelWrite(2'd3, 8'h40, 1'b1, 64'hCAFE0123BEEF4567);
    fetchOp(8'h40, 1'b1, "R11 fetch sees new");
    dataOp(1'b0, 2'd3, 8'h40, 64'h0, 1'b1);

    // R9: no response without request
    @(negedge clk);
    check(fetchRvalid === 1'b0 && dataRvalid === 1'b0, "R9 idle",
          128'({fetchRvalid, dataRvalid}), 128'(0));

    summary();
  end

endmodule